// File: doc/BRIEF.md
# Closed-Loop Bulk Erase Sequencer

This controller sits on the programmer side of a bulk-erasable memory and drives its erase algorithm to completion. After a start strobe it fires one whole-array erase pulse at once, with no preprogramming pass beforehand. It then reads the array back one byte at a time from address zero and expects every byte to read as all ones. A byte that still holds zeros causes another whole-array erase pulse. After that pulse, checking picks up again at the byte that failed rather than at address zero, so bytes that already passed are not read again.

Every erase pulse lasts a fixed number of clock cycles, set by a parameter. The total number of pulses is capped by a budget. The controller stops when one of two things happens: the top address reads as erased, or a byte still fails when the budget is used up. In either case it raises a one-cycle done strobe and leaves a pass flag and the count of pulses used on its outputs. The memory is read through a plain port. The controller drives an address and a read enable, and the data comes back one cycle later.

The state machine has five states. IDLE waits for a start. PULSE holds the erase request. READ drives the address. CHECK compares the returned byte. FINISH raises done. The transitions are:
- LAUNCH: IDLE to PULSE, on start.
- PULSE_END: PULSE to READ, when the pulse timer expires.
- ISSUE: READ to CHECK.
- NEXT: CHECK to READ, when the byte is erased and is not the top address.
- REERASE: CHECK to PULSE, when the byte fails and budget remains.
- ALL_GOOD: CHECK to FINISH with pass, when the top address is erased.
- GIVE_UP: CHECK to FINISH without pass, when the byte fails and the budget is spent.
- RETIRE: FINISH to IDLE.

Top module: `bulk_erase_seq`

## Requirements
- R1: After reset the block is in IDLE with busy, done, pass, erase_req and rd_en low and pulse_cnt zero.
- R2: A start seen in IDLE raises erase_req and busy in the next cycle with pulse_cnt equal to 1, and no read takes place before that first pulse.
- R3: Every erase pulse holds erase_req high for exactly PULSE_CYC consecutive cycles, and rd_en is never high while erase_req is high.
- R4: The first verify read after the first pulse goes to address 0. Reads then walk upward one address per passing byte. A byte passes when rd_data, sampled one cycle after its rd_en, equals all ones (8'hFF at the default width).
- R5: A byte that fails verify starts another erase pulse, and pulse_cnt increases by one. The first read after that pulse goes to the failing address, not to address 0.
- R6: When the top address (2^ADDR_W - 1) passes, done is high for exactly one cycle with pass high, and pulse_cnt equals the number of pulses issued.
- R7: When a byte fails while pulse_cnt equals MAX_PULSES (default 30), the block issues no further pulse. It raises done with pass low and pulse_cnt equal to MAX_PULSES.
- R8: A start that arrives while busy is high is ignored and does not change the read sequence, pulse count or result.
- R9: After done, pass and pulse_cnt keep their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an erase run when idle |
| erase_req | output | 1 | High for the length of each erase pulse |
| rd_en | output | 1 | Verify read request |
| rd_addr | output | ADDR_W | Verify read address |
| rd_data | input | DATA_W | Byte returned one cycle after rd_en |
| busy | output | 1 | High while pulsing or verifying |
| done | output | 1 | One-cycle strobe at the end of a run |
| pass | output | 1 | Result of the last run: all bytes erased |
| pulse_cnt | output | CNT_W | Erase pulses used by the current or last run |

## Verification
The bench models a memory in which each byte needs its own number of pulses before it reads as erased. It predicts the exact read count and the address order from a walk over those thresholds. A design that restarted at address 0 after a re-erase would produce more reads than predicted, and reads at the wrong addresses. Thresholds that end exactly at the budget, one beyond it, and at the top address test the limit. A design that was off by one would issue a 31st pulse, give up one pulse early, or miss the last byte. The bench also measures the width of every pulse and sends a start in the middle of a run. A wrong pulse counter or an unguarded start would show up as wrong pulse lengths or a restarted walk.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_READ,
        ST_CHECK,
        ST_FINISH
    } ers_state_t;
endpackage

// File: rtl/ers_pulse_timer.sv
module ers_pulse_timer #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int TW = $clog2(PULSE_CYC + 1);

    logic [TW-1:0] cnt;

    assign last = run && (cnt == TW'(PULSE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= last ? '0 : cnt + 1'b1;
        else
            cnt <= '0;
    end

    // R3: the count never runs past the pulse length
    a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < TW'(PULSE_CYC)));
endmodule

// File: rtl/ers_addr_walk.sv
module ers_addr_walk #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              mark,
    input  logic              reload,
    output logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] resume,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    assign at_end = (cur == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            resume <= '0;
        end else if (clear) begin
            cur    <= '0;
            resume <= '0;
        end else begin
            if (reload)
                cur <= resume;
            else if (step)
                cur <= cur + 1'b1;
            if (mark)
                resume <= cur;
        end
    end

    // R4: the walk never steps past the top address
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !reload) |-> !at_end);
endmodule

// File: rtl/ers_pulse_budget.sv
module ers_pulse_budget #(
    parameter int MAX_PULSES = 30,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    assign at_limit = (count == CNT_W'(MAX_PULSES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= bump ? CNT_W'(1) : '0;
        else if (bump && !at_limit)
            count <= count + 1'b1;
    end

    // R7: the budget is never exceeded
    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAX_PULSES));
endmodule

// File: rtl/bulk_erase_seq.sv
module bulk_erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 16,
    parameter int MAX_PULSES = 30,
    parameter int CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              erase_req,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [CNT_W-1:0]  pulse_cnt
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    ers_state_t state, state_nx;

    logic t_last;
    logic w_clear, w_step, w_mark, w_reload, w_end;
    logic b_clear, b_bump, b_limit;
    logic set_pass;
    logic [ADDR_W-1:0] walk_cur, walk_resume;

    ers_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_PULSE),
        .last (t_last)
    );

    ers_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (w_clear),
        .step  (w_step),
        .mark  (w_mark),
        .reload(w_reload),
        .cur   (walk_cur),
        .resume(walk_resume),
        .at_end(w_end)
    );

    ers_pulse_budget #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (b_clear),
        .bump    (b_bump),
        .count   (pulse_cnt),
        .at_limit(b_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state and control strobes
    always_comb begin
        state_nx = state;
        w_clear  = 1'b0;
        w_step   = 1'b0;
        w_mark   = 1'b0;
        w_reload = 1'b0;
        b_clear  = 1'b0;
        b_bump   = 1'b0;
        set_pass = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin                 // LAUNCH
                    state_nx = ST_PULSE;
                    w_clear  = 1'b1;
                    b_clear  = 1'b1;
                    b_bump   = 1'b1;
                end
            end
            ST_PULSE: begin
                if (t_last) begin                // PULSE_END
                    state_nx = ST_READ;
                    w_reload = 1'b1;
                end
            end
            ST_READ: begin
                state_nx = ST_CHECK;             // ISSUE
            end
            ST_CHECK: begin
                if (rd_data == ERASED) begin
                    if (w_end) begin             // ALL_GOOD
                        state_nx = ST_FINISH;
                        set_pass = 1'b1;
                    end else begin               // NEXT
                        state_nx = ST_READ;
                        w_step   = 1'b1;
                    end
                end else if (b_limit) begin      // GIVE_UP
                    state_nx = ST_FINISH;
                end else begin                   // REERASE
                    state_nx = ST_PULSE;
                    w_mark   = 1'b1;
                    b_bump   = 1'b1;
                end
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;              // RETIRE
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        erase_req = (state == ST_PULSE);
        rd_en     = (state == ST_READ);
        rd_addr   = walk_cur;
        busy      = (state == ST_PULSE) || (state == ST_READ) || (state == ST_CHECK);
        done      = (state == ST_FINISH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pass <= 1'b0;
        else if (w_clear)
            pass <= 1'b0;
        else if (set_pass)
            pass <= 1'b1;
    end

    // R2: a start while idle begins a pulse next cycle
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> (erase_req && busy));
    // R3: no read overlaps a pulse
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !rd_en);
    // R5: the first read after a pulse goes to the stored resume address
    a_r5_resume: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_req) |-> (rd_en && rd_addr == walk_resume));
    // R6: done lasts a single cycle
    a_r6_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a failed run has spent the whole budget
    a_r7_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (pulse_cnt == CNT_W'(MAX_PULSES)));
    // R9: result holds while idle without start
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !start) |=> ($stable(pass) && $stable(pulse_cnt)));
endmodule

// File: tb/bulk_erase_seq_test.sv
module bulk_erase_seq_test;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int PULSE_CYC  = 16;
    localparam int MAX_PULSES = 30;
    localparam int CNT_W      = $clog2(MAX_PULSES + 1);
    localparam int N          = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              erase_req, rd_en, busy, done, pass;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data = '0;
    logic [CNT_W-1:0]  pulse_cnt;

    int total = 0;
    int bad   = 0;

    int thr [N];
    int seen, reads, exp_a, width, width_err, addr_err, overlap_err;
    logic prev_er = 1'b0;
    int cycles = 0;

    always #10 clk = ~clk;

    bulk_erase_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC),
        .MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .erase_req(erase_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .done(done), .pass(pass), .pulse_cnt(pulse_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model and monitors, sampled away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prev_er && !erase_req) begin
                seen++;
                if (width != PULSE_CYC) width_err++;
                width = 0;
            end
            if (erase_req) width++;
            prev_er = erase_req;
            if (erase_req && rd_en) overlap_err++;
            if (rd_en) begin
                reads++;
                if (int'(rd_addr) != exp_a) addr_err++;
                if (seen >= thr[rd_addr]) begin
                    rd_data = '1;
                    if (int'(rd_addr) == exp_a) exp_a++;
                end else begin
                    rd_data = DATA_W'(8'hA5);
                end
            end
        end
    end

    // expected outcome from the requirements: resume walk under a budget
    function automatic void predict(output bit e_pass, output int e_cnt, output int e_reads);
        int a = 0;
        int p = 1;
        e_reads = 0;
        e_pass  = 1'b0;
        forever begin
            e_reads++;
            if (p >= thr[a]) begin
                if (a == N - 1) begin
                    e_pass = 1'b1;
                    break;
                end
                a++;
            end else if (p == MAX_PULSES) begin
                break;
            end else begin
                p++;
            end
        end
        e_cnt = p;
    endfunction

    task automatic run_trial(input string name, input bit poke);
        bit e_pass;
        int e_cnt, e_reads;
        int n;
        bit got_done;
        int f_pass, f_cnt;
        predict(e_pass, e_cnt, e_reads);
        @(negedge clk);
        seen = 0; reads = 0; exp_a = 0; width = 0;
        width_err = 0; addr_err = 0; overlap_err = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: pulse begins at once, nothing read first
        check(erase_req && busy && pulse_cnt == 1 && reads == 0,
              {"R2 ", name}, {erase_req, busy}, 3);
        got_done = 1'b0;
        n = 0;
        while (!got_done && n < 20000) begin
            @(negedge clk);
            n++;
            if (poke && (n == 5 || n == PULSE_CYC + 9)) start = 1'b1;   // R8 stray start
            else start = 1'b0;
            if (done) got_done = 1'b1;
        end
        start = 1'b0;
        check(got_done, {"R6 done ", name}, got_done, 1);
        check(pass == e_pass, {"R6/R7 pass ", name}, pass, e_pass);
        check(int'(pulse_cnt) == e_cnt, {"R6/R7 pulse_cnt ", name}, pulse_cnt, e_cnt);
        check(seen == e_cnt, {"R7 pulses issued ", name}, seen, e_cnt);
        check(reads == e_reads, {"R5 read count ", name}, reads, e_reads);
        check(addr_err == 0, {"R4/R5 read order ", name}, addr_err, 0);
        check(width_err == 0 && overlap_err == 0, {"R3 pulse shape ", name},
              width_err + overlap_err, 0);
        if (poke) check(reads == e_reads && int'(pulse_cnt) == e_cnt,
                        {"R8 start ignored ", name}, reads, e_reads);
        f_pass = pass;
        f_cnt  = pulse_cnt;
        @(negedge clk);
        check(!done, {"R6 single-cycle done ", name}, done, 0);
        repeat (3) @(negedge clk);
        check(int'(pass) == f_pass && int'(pulse_cnt) == f_cnt && !busy,
              {"R9 result held ", name}, pulse_cnt, f_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 200000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        foreach (thr[i]) thr[i] = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !pass && !erase_req && !rd_en && pulse_cnt == 0,
              "R1 reset state", {busy, done, pass, erase_req, rd_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && pulse_cnt == 0, "R1 idle after reset", busy, 0);

        foreach (thr[i]) thr[i] = 1;
        run_trial("all erase in one pulse", 1'b0);

        foreach (thr[i]) thr[i] = 0;
        run_trial("already blank still pulses", 1'b0);

        foreach (thr[i]) thr[i] = 1;
        thr[N-1] = MAX_PULSES;
        run_trial("top byte at budget", 1'b0);

        foreach (thr[i]) thr[i] = 1;
        thr[10] = MAX_PULSES + 1;
        run_trial("byte beyond budget", 1'b0);

        foreach (thr[i]) thr[i] = 1 + i / 8;
        run_trial("rising thresholds resume", 1'b0);

        foreach (thr[i]) thr[i] = 1 + (i % 5);
        run_trial("stray start mid-run", 1'b1);

        for (int t = 0; t < 8; t++) begin
            foreach (thr[i]) thr[i] = (($urandom % 4) == 0) ? 1 + int'($urandom % 32) : 1;
            run_trial($sformatf("random %0d", t), t[0]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule